// File: doc/BRIEF.md
# Key-Unlocked Configuration Write Sequencer

This block listens to every byte written to one fixed, write-only configuration port. While it is locked it compares each byte against a 32-byte unlock sequence. When all 32 bytes arrive in order, it enters a private configuration mode. In that mode, the bytes that follow alternate between a register index and one or two value bytes. These pairs build a resource record for one logical device at a time: a device number, three 16-bit I/O bases, two interrupt lines, two DMA channels and an activate flag.

A record is handed downstream as a one-cycle commit strobe with the captured fields. This happens when the next device is selected, or when the exit index closes the mode. A card-select-number write goes out on a separate strobe. A lock input, driven from a configuration bit, holds the sequencer idle while it is set. The I/O decoding that uses the committed records is outside this block.

Top module: `cfg_unlock_seq`

## Requirements
- R1: After reset, cfg_mode, commit_valid and csn_valid are all 0.
- R2: The unlock sequence has 32 bytes. Byte 0 is 0x96 and byte 1 is 0x35. Each later byte is the previous byte shifted right by one, with bit 7 set to the XOR of the previous byte's bits 0 and 1, so the last byte is 0x1A. cfg_mode rises in the cycle after the 32nd matching write. After the mode is left, a complete new sequence is needed to re-enter it.
- R3: A byte that does not match the expected sequence byte returns the match position to the start. That byte is not itself tested as the first byte of a new attempt.
- R4: In configuration mode, an index byte of 0x79 leaves the mode. If a device has been selected, the pending record is committed: commit_valid is high for exactly one cycle, the cycle after that write.
- R5: Index 0x15 selects a device, and its value byte becomes the device number. If a record is pending, that record is committed first with its old device number, and its other fields carry over into the new record. The first selection after entering the mode starts from a record with all fields zero.
- R6: Indices 0x47, 0x48 and 0x42 write I/O base slots 0, 1 and 2. Each takes two value bytes, the high byte first and then the low byte.
- R7: Indices 0x22 and 0x27 set interrupt slots 0 and 1 to bits 3:0 of the value. Indices 0x2A and 0x25 set DMA slots 0 and 1 to bits 2:0 of the value.
- R8: Index 0x33 sets the activate flag to bit 0 of the value.
- R9: Index 0x06 pulses csn_valid for one cycle, with csn_value equal to the value byte. No device needs to be selected for this.
- R10: Resource writes made before any device has been selected are ignored. An exit with no device selected commits nothing.
- R11: Every value byte, including the value byte of an unknown index, returns the sequencer to index state. A value byte equal to 0x79 does not leave the mode.
- R12: While key_lock is 1, cfg_mode drops in the next cycle, the match position is cleared, the pending record is dropped without a commit, and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_lock | input | 1 | 1 holds the sequencer idle and locked |
| wr_en | input | 1 | Byte write strobe for the configuration port |
| wr_data | input | 8 | Written byte |
| cfg_mode | output | 1 | 1 while configuration mode is open |
| csn_valid | output | 1 | One-cycle strobe for a new card select number |
| csn_value | output | 8 | Card select number |
| commit_valid | output | 1 | One-cycle strobe: a device record is committed |
| commit_dev | output | 8 | Committed device number |
| commit_io0 | output | 16 | Committed I/O base slot 0 |
| commit_io1 | output | 16 | Committed I/O base slot 1 |
| commit_io2 | output | 16 | Committed I/O base slot 2 |
| commit_irq0 | output | 4 | Committed interrupt slot 0 |
| commit_irq1 | output | 4 | Committed interrupt slot 1 |
| commit_dma0 | output | 3 | Committed DMA slot 0 |
| commit_dma1 | output | 3 | Committed DMA slot 1 |
| commit_active | output | 1 | Committed activate flag |

## Verification
Every result of this block is due exactly one clock edge after the write or lock that causes it: mode entry on the 32nd key byte, mode exit, the commit strobe with its record, and the card-select strobe. The bench drives each byte on a falling edge and holds the strobe for one cycle. It samples the outputs on the next falling edge, which is the only cycle in which a strobe is high. The bench then samples again one cycle later to confirm that the strobes lasted a single cycle.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam int IO_SLOTS  = 3;
  localparam int IO_W      = 16;
  localparam int IRQ_SLOTS = 2;
  localparam int IRQ_W     = 4;
  localparam int DMA_SLOTS = 2;
  localparam int DMA_W     = 3;

  localparam logic [7:0] IDX_EXIT = 8'h79;
  localparam logic [7:0] IDX_CSN  = 8'h06;
  localparam logic [7:0] IDX_LDEV = 8'h15;
  localparam logic [7:0] IDX_IO0  = 8'h47;
  localparam logic [7:0] IDX_IO1  = 8'h48;
  localparam logic [7:0] IDX_IO2  = 8'h42;
  localparam logic [7:0] IDX_IRQ0 = 8'h22;
  localparam logic [7:0] IDX_IRQ1 = 8'h27;
  localparam logic [7:0] IDX_DMA0 = 8'h2A;
  localparam logic [7:0] IDX_DMA1 = 8'h25;
  localparam logic [7:0] IDX_ACT  = 8'h33;

  typedef enum logic [1:0] {
    SQ_LOCKED   = 2'd0,
    SQ_INDEX    = 2'd1,
    SQ_VALUE    = 2'd2,
    SQ_VALUE_LO = 2'd3
  } sq_state_e;

  typedef struct packed {
    logic [7:0]                      dev;
    logic [IO_SLOTS-1:0][IO_W-1:0]   io;
    logic [IRQ_SLOTS-1:0][IRQ_W-1:0] irq;
    logic [DMA_SLOTS-1:0][DMA_W-1:0] dma;
    logic                            active;
  } dev_rec_t;

  // Unlock byte n: fixed first byte, then a right-shift chain seeded with 0x35
  // whose new top bit is the XOR of the two lowest bits.
  function automatic logic [7:0] key_byte(input int unsigned n);
    logic [7:0] b;
    if (n == 0) return 8'h96;
    b = 8'h35;
    for (int unsigned i = 1; i < n; i++) b = {b[0] ^ b[1], b[7:1]};
    return b;
  endfunction

  // I/O base slot addressed by an index byte; 3 means none.
  function automatic logic [1:0] io_slot(input logic [7:0] idx);
    case (idx)
      IDX_IO0: return 2'd0;
      IDX_IO1: return 2'd1;
      IDX_IO2: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/cfgseq_key_match.sv
module cfgseq_key_match #(
  parameter int KEY_LEN = 32,
  localparam int POS_W = $clog2(KEY_LEN)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       byte_en,
  input  logic [7:0] byte_in,
  output logic       key_done
);

  logic [7:0] key_tbl [KEY_LEN];

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign key_tbl[g] = cfgseq_pkg::key_byte(g);
  end

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;
  logic             hit;

  always_comb begin
    hit      = (byte_in == key_tbl[pos_q]);
    pos_d    = pos_q;
    key_done = 1'b0;
    pos_en   = clear | byte_en;
    if (clear) begin
      pos_d = '0;
    end else if (byte_en) begin
      if (!hit) begin
        pos_d = '0;
      end else if (pos_q == POS_W'(KEY_LEN - 1)) begin
        pos_d    = '0;
        key_done = 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       key_done,
  output sq_state_e  state_q,
  output logic [7:0] idx_q
);

  sq_state_e  state_d;
  logic [7:0] idx_d;
  logic       st_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    st_en   = clear | wr_en;
    if (clear) begin
      state_d = SQ_LOCKED;
    end else if (wr_en) begin
      case (state_q)
        SQ_LOCKED: if (key_done) state_d = SQ_INDEX;
        SQ_INDEX: begin
          if (wr_data == IDX_EXIT) begin
            state_d = SQ_LOCKED;
          end else begin
            idx_d   = wr_data;
            state_d = SQ_VALUE;
          end
        end
        SQ_VALUE:    state_d = (io_slot(idx_q) != 2'd3) ? SQ_VALUE_LO : SQ_INDEX;
        SQ_VALUE_LO: state_d = SQ_INDEX;
        default:     state_d = SQ_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_LOCKED;
      idx_q   <= '0;
    end else if (st_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/cfgseq_record.sv
module cfgseq_record
  import cfgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  sq_state_e  state_q,
  input  logic [7:0] idx_q,
  output logic       commit_valid,
  output dev_rec_t   commit_rec,
  output logic       csn_valid,
  output logic [7:0] csn_value
);

  dev_rec_t   rec_q, rec_d, crec_q;
  logic       vld_q, vld_d;
  logic       cv_q, cv_d, crec_ld;
  logic       csnv_q, csnv_d, csn_ld;
  logic [7:0] csn_q;
  logic [1:0] slot;

  always_comb begin
    rec_d   = rec_q;
    vld_d   = vld_q;
    cv_d    = 1'b0;
    crec_ld = 1'b0;
    csnv_d  = 1'b0;
    csn_ld  = 1'b0;
    slot    = io_slot(idx_q);
    if (clear) begin
      vld_d = 1'b0;
    end else if (wr_en) begin
      case (state_q)
        SQ_INDEX: begin
          if (wr_data == IDX_EXIT) begin
            cv_d    = vld_q;
            crec_ld = vld_q;
            vld_d   = 1'b0;
          end
        end
        SQ_VALUE: begin
          if (idx_q == IDX_CSN) begin
            csnv_d = 1'b1;
            csn_ld = 1'b1;
          end else if (idx_q == IDX_LDEV) begin
            if (vld_q) begin
              cv_d    = 1'b1;
              crec_ld = 1'b1;
            end else begin
              rec_d = '0;
            end
            rec_d.dev = wr_data;
            vld_d     = 1'b1;
          end else if (vld_q) begin
            for (int s = 0; s < IO_SLOTS; s++)
              if (slot == 2'(s)) rec_d.io[s] = {wr_data, 8'h00};
            case (idx_q)
              IDX_IRQ0: rec_d.irq[0] = wr_data[IRQ_W-1:0];
              IDX_IRQ1: rec_d.irq[1] = wr_data[IRQ_W-1:0];
              IDX_DMA0: rec_d.dma[0] = wr_data[DMA_W-1:0];
              IDX_DMA1: rec_d.dma[1] = wr_data[DMA_W-1:0];
              IDX_ACT:  rec_d.active = wr_data[0];
              default:  ;
            endcase
          end
        end
        SQ_VALUE_LO: begin
          if (vld_q)
            for (int s = 0; s < IO_SLOTS; s++)
              if (slot == 2'(s)) rec_d.io[s][7:0] = wr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      vld_q  <= 1'b0;
      cv_q   <= 1'b0;
      csnv_q <= 1'b0;
    end else begin
      rec_q  <= rec_d;
      vld_q  <= vld_d;
      cv_q   <= cv_d;
      csnv_q <= csnv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crec_q <= '0;
    else if (crec_ld) crec_q <= rec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csn_q <= '0;
    else if (csn_ld) csn_q <= wr_data;
  end

  assign commit_valid = cv_q;
  assign commit_rec   = crec_q;
  assign csn_valid    = csnv_q;
  assign csn_value    = csn_q;

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import cfgseq_pkg::*;
#(
  parameter int KEY_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_lock,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic        cfg_mode,
  output logic        csn_valid,
  output logic [7:0]  csn_value,
  output logic        commit_valid,
  output logic [7:0]  commit_dev,
  output logic [15:0] commit_io0,
  output logic [15:0] commit_io1,
  output logic [15:0] commit_io2,
  output logic [3:0]  commit_irq0,
  output logic [3:0]  commit_irq1,
  output logic [2:0]  commit_dma0,
  output logic [2:0]  commit_dma1,
  output logic        commit_active
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sq_state_e  state_q;
  logic [7:0] idx_q;
  logic       key_done;
  logic       key_en;
  dev_rec_t   crec;

  assign key_en = wr_en & (state_q == SQ_LOCKED);

  cfgseq_key_match #(.KEY_LEN(KEY_LEN)) u_key (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clear    (key_lock),
    .byte_en  (key_en),
    .byte_in  (wr_data),
    .key_done (key_done)
  );

  cfgseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clear    (key_lock),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .key_done (key_done),
    .state_q  (state_q),
    .idx_q    (idx_q)
  );

  cfgseq_record u_rec (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .clear        (key_lock),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .state_q      (state_q),
    .idx_q        (idx_q),
    .commit_valid (commit_valid),
    .commit_rec   (crec),
    .csn_valid    (csn_valid),
    .csn_value    (csn_value)
  );

  assign cfg_mode      = (state_q != SQ_LOCKED);
  assign commit_dev    = crec.dev;
  assign commit_io0    = crec.io[0];
  assign commit_io1    = crec.io[1];
  assign commit_io2    = crec.io[2];
  assign commit_irq0   = crec.irq[0];
  assign commit_irq1   = crec.irq[1];
  assign commit_dma0   = crec.dma[0];
  assign commit_dma1   = crec.dma[1];
  assign commit_active = crec.active;

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker #(
  parameter int KEY_LEN = 32
) (
  input logic       clk,
  input logic       rst_core_n,
  input logic       key_lock,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       cfg_mode,
  input logic       commit_valid,
  input logic       csn_valid
);

  localparam logic [7:0] LAST_KEY = cfgseq_pkg::key_byte(KEY_LEN - 1);

  // R2: mode opens only on a write of the final sequence byte
  assert_entry_on_last_key_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(cfg_mode) |-> ($past(wr_en) && $past(wr_data) == LAST_KEY && !$past(key_lock)));

  // R2: without a write or a lock the mode does not change
  assert_mode_holds_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!$past(wr_en) && !$past(key_lock)) |-> $stable(cfg_mode));

  // R4: mode closes only through the exit index or the lock
  assert_exit_cause_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(cfg_mode) |-> ($past(key_lock) || ($past(wr_en) && $past(wr_data) == 8'h79)));

  // R4: a commit always follows a write made in configuration mode
  assert_commit_after_write_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    commit_valid |-> ($past(wr_en) && $past(cfg_mode) && !$past(key_lock)));

  // R9: the card select strobe follows a write made in configuration mode
  assert_csn_after_write_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    csn_valid |-> ($past(wr_en) && $past(cfg_mode)));

  // R11: one write yields at most one kind of strobe
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(commit_valid && csn_valid));

  // R12: the lock closes the mode in the next cycle
  assert_lock_closes_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    key_lock |=> !cfg_mode);

endmodule

bind cfg_unlock_seq cfgseq_checker #(.KEY_LEN(KEY_LEN)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .key_lock     (key_lock),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .cfg_mode     (cfg_mode),
  .commit_valid (commit_valid),
  .csn_valid    (csn_valid)
);

// File: tb/cfg_unlock_seq_tb.sv
module cfg_unlock_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_lock = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        cfg_mode, csn_valid, commit_valid, commit_active;
  logic [7:0]  csn_value, commit_dev;
  logic [15:0] commit_io0, commit_io1, commit_io2;
  logic [3:0]  commit_irq0, commit_irq1;
  logic [2:0]  commit_dma0, commit_dma1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_unlock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .key_lock(key_lock), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_mode(cfg_mode), .csn_valid(csn_valid), .csn_value(csn_value),
    .commit_valid(commit_valid), .commit_dev(commit_dev),
    .commit_io0(commit_io0), .commit_io1(commit_io1), .commit_io2(commit_io2),
    .commit_irq0(commit_irq0), .commit_irq1(commit_irq1),
    .commit_dma0(commit_dma0), .commit_dma1(commit_dma1), .commit_active(commit_active)
  );

  localparam logic [7:0] KEY [32] = '{
    8'h96, 8'h35, 8'h9A, 8'hCD, 8'hE6, 8'hF3, 8'h79, 8'hBC,
    8'h5E, 8'hAF, 8'h57, 8'h2B, 8'h15, 8'h8A, 8'hC5, 8'hE2,
    8'hF1, 8'hF8, 8'h7C, 8'h3E, 8'h9F, 8'h4F, 8'h27, 8'h13,
    8'h09, 8'h84, 8'h42, 8'hA1, 8'hD0, 8'h68, 8'h34, 8'h1A};

  // vector: data, expected cfg_mode, expected commit, dev, io0, irq0, active
  function automatic logic [38:0] v(input logic [7:0] d, input logic c, input logic m,
                                    input logic [7:0] dv, input logic [15:0] io,
                                    input logic [3:0] iq, input logic a);
    return {d, c, m, dv, io, iq, a};
  endfunction

  localparam int NV = 18;
  localparam logic [38:0] SESS [NV] = '{
    v(8'h22, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R10 irq before any device
    v(8'h05, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h15, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R5 first device, nothing to commit
    v(8'h00, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h47, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R6 slot 0 high then low
    v(8'h05, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h34, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h22, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R7 low four bits
    v(8'h1B, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h33, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R8
    v(8'h03, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h15, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R5 next device commits the old one
    v(8'h02, 1, 1, 8'h00, 16'h0534, 4'hB, 1),
    v(8'h50, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R11 unknown index
    v(8'h79, 1, 0, 8'h00, 16'h0000, 4'h0, 0),  // R11 value 0x79 stays in mode
    v(8'h22, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h07, 1, 0, 8'h00, 16'h0000, 4'h0, 0),
    v(8'h79, 0, 1, 8'h02, 16'h0534, 4'h7, 1)   // R4 exit commits, R5 carry-over
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one byte on a falling edge; returns on the next falling edge,
  // the cycle in which the write's results are visible.
  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic send_key(input int first, input int last);
    for (int i = first; i <= last; i++) wr(KEY[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cfg_mode", cfg_mode, 0);
    check("R1 commit_valid", commit_valid, 0);
    check("R1 csn_valid", csn_valid, 0);

    // R3 a mismatch restarts and is not retried as a first byte
    wr(8'h96);
    wr(8'h96);
    send_key(1, 31);
    check("R3 no entry after broken sequence", cfg_mode, 0);

    // R2 entry timing
    send_key(0, 30);
    check("R2 still locked after 31 bytes", cfg_mode, 0);
    wr(KEY[31]);
    check("R2 open after 32nd byte", cfg_mode, 1);

    // Table walk: R4 R5 R6 R7 R8 R10 R11
    for (int n = 0; n < NV; n++) begin
      logic [38:0] e;
      e = SESS[n];
      wr(e[38:31]);
      check($sformatf("R11 cfg_mode step %0d", n), cfg_mode, e[30]);
      check($sformatf("R4 commit_valid step %0d", n), commit_valid, e[29]);
      if (e[29]) begin
        check($sformatf("R5 commit_dev step %0d", n), commit_dev, e[28:21]);
        check($sformatf("R6 commit_io0 step %0d", n), commit_io0, e[20:5]);
        check($sformatf("R7 commit_irq0 step %0d", n), commit_irq0, e[4:1]);
        check($sformatf("R8 commit_active step %0d", n), commit_active, e[0]);
      end
    end
    @(negedge clk);
    check("R4 commit lasts one cycle", commit_valid, 0);

    // R2 re-entry needs the full sequence again
    send_key(1, 31);
    check("R2 partial sequence after exit", cfg_mode, 0);

    // R9 card select without a device, then R5 R6 R7 on the other slots
    send_key(0, 31);
    check("R2 reopen", cfg_mode, 1);
    wr(8'h06);
    wr(8'hC3);
    check("R9 csn_valid", csn_valid, 1);
    check("R9 csn_value", csn_value, 8'hC3);
    check("R9 no commit", commit_valid, 0);
    @(negedge clk);
    check("R9 csn lasts one cycle", csn_valid, 0);
    wr(8'h15); wr(8'h01);
    check("R5 no commit on first select", commit_valid, 0);
    wr(8'h48); wr(8'h02); wr(8'h20);
    wr(8'h42); wr(8'h03); wr(8'h88);
    wr(8'h27); wr(8'hFA);
    wr(8'h2A); wr(8'hFD);
    wr(8'h25); wr(8'h0E);
    wr(8'h79);
    check("R4 commit on exit", commit_valid, 1);
    check("R5 dev", commit_dev, 8'h01);
    check("R5 fresh record io0", commit_io0, 16'h0000);
    check("R5 fresh record irq0", commit_irq0, 0);
    check("R5 fresh record active", commit_active, 0);
    check("R6 io1", commit_io1, 16'h0220);
    check("R6 io2", commit_io2, 16'h0388);
    check("R7 irq1", commit_irq1, 4'hA);
    check("R7 dma0", commit_dma0, 3'd5);
    check("R7 dma1", commit_dma1, 3'd6);
    check("R4 closed", cfg_mode, 0);

    // R10 exit with no device commits nothing
    send_key(0, 31);
    wr(8'h79);
    check("R10 no commit without device", commit_valid, 0);
    check("R10 closed", cfg_mode, 0);

    // R12 lock closes the mode and drops the record
    send_key(0, 31);
    wr(8'h15); wr(8'h04);
    @(negedge clk);
    key_lock = 1'b1;
    @(negedge clk);
    check("R12 lock closes mode", cfg_mode, 0);
    check("R12 no commit on lock", commit_valid, 0);
    send_key(0, 31);
    check("R12 key ignored while locked", cfg_mode, 0);
    key_lock = 1'b0;
    wr(8'h79);
    check("R12 record dropped", commit_valid, 0);
    send_key(0, 15);
    @(negedge clk);
    key_lock = 1'b1;
    @(negedge clk);
    key_lock = 1'b0;
    send_key(16, 31);
    check("R12 lock clears progress", cfg_mode, 0);
    send_key(0, 31);
    check("R12 reopen after unlock", cfg_mode, 1);
    wr(8'h79);
    check("R12 no stale record", commit_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule